// File: doc/BRIEF.md
# Two-Requester Hazard-Free Handover Arbiter

This block shares one resource between two requesters, A and B. It is a clocked rendering of a fundamental-mode flow-table machine. The state code is chosen so that no single step ever changes both state bits. The resource is either free, owned by A, or owned by B. A grant stays with its owner for as long as that owner keeps requesting, even when the other side is also asking.

A direct change of owner would move the state code from 01 to 10, which flips two bits at once. The spare code 11 is used instead as a one-cycle handover step in which nobody holds the grant. The machine then enters the new owner's state. Every edge of the state graph therefore links codes that differ in exactly one bit. The grant outputs come from the state register alone, with no logic from the request inputs, so they cannot glitch on a request change.

Top module: `arb2_handover`

## Requirements
- R1: While `rst_n` is low, both grants are low. Reset takes effect at once, without waiting for a clock edge. After release the machine starts in the free state (code 00).
- R2: In the free state with no request, both grants stay low at every clock edge.
- R3: In the free state with exactly one request high, that requester's grant is high after the next rising clock edge.
- R4: In the free state with both requests high, the grant goes to A after the next edge (parameter `PRIO_A` = 1, the default).
- R5: While the owner keeps its request high, its grant stays high, whatever the other request does.
- R6: When the owner drops its request and the other request is low, both grants are low after the next edge.
- R7: When the owner drops its request while the other request is high, both grants are low for exactly one cycle (handover code 11). The other requester's grant is high after the second edge.
- R8: `gnt_a` and `gnt_b` are never high together.
- R9: Every change of the state code (free 00, A 01, B 10, handover 11) flips exactly one bit. Seen at the ports, the grant pair never goes directly from A owning to B owning, or the reverse.
- R10: The handover step always moves on to the requester it was started for, one cycle later. This holds even if that request drops during the handover.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset; takes effect at once, release is synchronised to `clk` |
| req_a | input | 1 | Request from requester A |
| req_b | input | 1 | Request from requester B |
| gnt_a | output | 1 | Grant to requester A |
| gnt_b | output | 1 | Grant to requester B |

## Verification
The request pair is driven through all four combinations from the free state: none, A only, B only, and both. These separate the idle hold, the single grants and the tie-break. In each owner state the bench raises the other request while the owner holds, which shows that the grant is kept. It then drops the owner's request with the rival idle and with the rival waiting, which tells a plain release apart from a handover and its empty cycle. A rival that withdraws during the handover shows that the step is committed once it starts. An asynchronous reset applied while a grant is held shows that the grants clear at once.

// File: rtl/arb2_pkg.sv
package arb2_pkg;
  // Codes are adjacent along every used edge: 00-01, 00-10, 01-11, 10-11
  typedef enum logic [1:0] {
    ST_FREE  = 2'b00,
    ST_OWN_A = 2'b01,
    ST_OWN_B = 2'b10,
    ST_HAND  = 2'b11
  } arb_st_e;
endpackage

// File: rtl/arb2_rst_sync.sv
module arb2_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/arb2_next.sv
module arb2_next
  import arb2_pkg::*;
#(
  parameter bit PRIO_A = 1'b1
) (
  input  arb_st_e cur,
  input  logic    tgt_b,
  input  logic    req_a,
  input  logic    req_b,
  output arb_st_e nxt,
  output logic    hand_en,
  output logic    hand_to_b
);
  arb_st_e tie_st;

  generate
    if (PRIO_A) begin : g_tie_a
      assign tie_st = ST_OWN_A;
    end else begin : g_tie_b
      assign tie_st = ST_OWN_B;
    end
  endgenerate

  always_comb begin
    nxt = cur;
    unique case (cur)
      ST_FREE: begin
        unique case ({req_b, req_a})
          2'b01:   nxt = ST_OWN_A;
          2'b10:   nxt = ST_OWN_B;
          2'b11:   nxt = tie_st;
          default: nxt = ST_FREE;
        endcase
      end
      ST_OWN_A: if (!req_a) nxt = req_b ? ST_HAND : ST_FREE;
      ST_OWN_B: if (!req_b) nxt = req_a ? ST_HAND : ST_FREE;
      ST_HAND:  nxt = tgt_b ? ST_OWN_B : ST_OWN_A;
      default:  nxt = ST_FREE;
    endcase
  end

  // Handover target latched on entry: opposite of the departing owner
  assign hand_en   = (nxt == ST_HAND) && (cur != ST_HAND);
  assign hand_to_b = (cur == ST_OWN_A);
endmodule

// File: rtl/arb2_state_reg.sv
module arb2_state_reg
  import arb2_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  arb_st_e nxt,
  input  logic    hand_en,
  input  logic    hand_to_b,
  output arb_st_e cur,
  output logic    tgt_b
);
  arb_st_e cur_q;
  logic    tgt_q;
  logic    upd_en;

  assign upd_en = (nxt != cur_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cur_q <= ST_FREE;
    else if (upd_en) cur_q <= nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tgt_q <= 1'b0;
    else if (hand_en) tgt_q <= hand_to_b;
  end

  assign cur   = cur_q;
  assign tgt_b = tgt_q;
endmodule

// File: rtl/arb2_grant_dec.sv
module arb2_grant_dec
  import arb2_pkg::*;
(
  input  arb_st_e cur,
  output logic    gnt_a,
  output logic    gnt_b
);
  assign gnt_a = (cur == ST_OWN_A);
  assign gnt_b = (cur == ST_OWN_B);
endmodule

// File: rtl/arb2_handover.sv
module arb2_handover
  import arb2_pkg::*;
#(
  parameter bit PRIO_A     = 1'b1,
  parameter int RST_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_a,
  input  logic req_b,
  output logic gnt_a,
  output logic gnt_b
);
  logic    rst_sync_n;
  arb_st_e cur_st;
  arb_st_e nxt_st;
  logic    tgt_b;
  logic    hand_en;
  logic    hand_to_b;

  arb2_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  arb2_next #(.PRIO_A(PRIO_A)) u_next (
    .cur       (cur_st),
    .tgt_b     (tgt_b),
    .req_a     (req_a),
    .req_b     (req_b),
    .nxt       (nxt_st),
    .hand_en   (hand_en),
    .hand_to_b (hand_to_b)
  );

  arb2_state_reg u_reg (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .nxt       (nxt_st),
    .hand_en   (hand_en),
    .hand_to_b (hand_to_b),
    .cur       (cur_st),
    .tgt_b     (tgt_b)
  );

  arb2_grant_dec u_dec (
    .cur   (cur_st),
    .gnt_a (gnt_a),
    .gnt_b (gnt_b)
  );
endmodule

// File: rtl/arb2_handover_chk.sv
module arb2_handover_chk #(
  parameter bit PRIO_A = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_a,
  input logic       req_b,
  input logic       gnt_a,
  input logic       gnt_b,
  input logic [1:0] st
);
  p_grant_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gnt_a && gnt_b));

  p_one_bit_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != $past(st)) |-> ($countones(st ^ $past(st)) == 1));

  p_single_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b00 && req_a && !req_b) |=> gnt_a);

  p_tie_break_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b00 && req_a && req_b) |=> (PRIO_A ? gnt_a : gnt_b));

  p_hold_owner_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_b && req_b) |=> gnt_b);

  p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_a && !req_a && !req_b) |=> (!gnt_a && !gnt_b));

  p_gap_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt_a && !req_a && req_b) |=> (!gnt_a && !gnt_b && st == 2'b11));

  p_hand_exit_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 2'b11) |=> (gnt_a || gnt_b));
endmodule

bind arb2_handover arb2_handover_chk #(.PRIO_A(PRIO_A)) u_chk (
  .clk   (clk),
  .rst_n (rst_sync_n),
  .req_a (req_a),
  .req_b (req_b),
  .gnt_a (gnt_a),
  .gnt_b (gnt_b),
  .st    (cur_st)
);

// File: tb/tb_arb2_handover.sv
`timescale 1ns/1ps
module tb_arb2_handover;
  logic clk = 1'b0;
  logic rst_n;
  logic req_a, req_b;
  logic gnt_a, gnt_b;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    logic  ea;
    logic  eb;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  logic [1:0] prev_g;
  bit mon_on = 1'b0;

  always #2 clk = ~clk;

  arb2_handover dut (
    .clk   (clk),
    .rst_n (rst_n),
    .req_a (req_a),
    .req_b (req_b),
    .gnt_a (gnt_a),
    .gnt_b (gnt_b)
  );

  task automatic check(input string tag, input logic [1:0] act, input logic [1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: {gnt_b,gnt_a} actual %b expected %b", tag, act, exp);
    end
  endtask

  // Driver: requests for the coming edge, with grants expected after it
  task automatic drive(input logic rb, input logic ra, input logic eb, input logic ea,
                       input string tag);
    exp_t it;
    @(negedge clk);
    req_a = ra;
    req_b = rb;
    it.ea = ea;
    it.eb = eb;
    it.tag = tag;
    exp_q.push_back(it);
  endtask

  // Monitor: samples 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        checks++;
        if ($countones(prev_g ^ {gnt_b, gnt_a}) > 1) begin
          errors++;
          $display("FAIL R9: grants stepped %b -> %b, expected at most one bit change",
                   prev_g, {gnt_b, gnt_a});
        end
        checks++;
        if (gnt_a && gnt_b) begin
          errors++;
          $display("FAIL R8: {gnt_b,gnt_a} actual 11 expected not 11");
        end
        prev_g = {gnt_b, gnt_a};
      end
      if (exp_q.size() > 0) begin
        exp_t it;
        it = exp_q.pop_front();
        check(it.tag, {gnt_b, gnt_a}, {it.eb, it.ea});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    errors++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    finish_run();
  end

  initial begin
    rst_n = 1'b0;
    req_a = 1'b0;
    req_b = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    check("R1 grants low in reset", {gnt_b, gnt_a}, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1 free after release", {gnt_b, gnt_a}, 2'b00);
    prev_g = 2'b00;
    mon_on = 1'b1;

    drive(0, 0, 0, 0, "R2 idle stays free");
    drive(0, 0, 0, 0, "R2 idle stays free again");
    drive(0, 1, 0, 1, "R3 single request A");
    drive(0, 1, 0, 1, "R5 A holds");
    drive(1, 1, 0, 1, "R5 A holds against B");
    drive(1, 0, 0, 0, "R7 handover gap A to B");
    drive(1, 0, 1, 0, "R7 B granted after gap");
    drive(1, 1, 1, 0, "R5 B holds against A");
    drive(0, 0, 0, 0, "R6 B releases to free");
    drive(1, 1, 0, 1, "R4 tie from free goes to A");
    drive(0, 0, 0, 0, "R6 A releases to free");
    drive(1, 0, 1, 0, "R3 single request B");
    drive(0, 1, 0, 0, "R7 handover gap B to A");
    drive(0, 0, 0, 1, "R10 handover completes after A withdrew");
    drive(0, 0, 0, 0, "R6 release after forced grant");
    drive(1, 0, 1, 0, "R3 B again");
    drive(0, 1, 0, 0, "R7 gap B to A second");
    drive(0, 1, 0, 1, "R7 A granted after gap");
    drive(1, 0, 0, 0, "R10 gap A to B");
    drive(0, 0, 1, 0, "R10 B granted though B withdrew");
    drive(0, 0, 0, 0, "R6 free at end");
    drive(0, 1, 0, 1, "R3 A before reset");

    wait (exp_q.size() == 0);
    @(negedge clk);
    mon_on = 1'b0;
    #0.5;
    rst_n = 1'b0;
    #0.5;
    check("R1 asynchronous clear while granted", {gnt_b, gnt_a}, 2'b00);
    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule